// File: doc/BRIEF.md
# Clause 22 Management Slave

This block is the responding end of the two-wire station management bus used to configure Ethernet physical-layer devices. A management master drives a clock line (MDC) and a shared bidirectional data line (MDIO). The slave watches the data line on each rising edge of the management clock and parses each frame. It first waits for the synchronising run of ones. It then decodes the start code, the operation, the device address and the register address. On a read it returns sixteen bits of register data, and on a write it accepts sixteen bits.

The register storage sits outside the block, behind a small parallel port. The port carries a register address, write data with a one-cycle write strobe, and a one-cycle read strobe with the returned read data. The block does not drive the pad itself. It provides an output value and an output enable, and the pad and pull-up are built around them. Both management lines are oversampled with a faster system clock, so the management clock may run at any rate up to a quarter of the system clock and may stop at any time.

Top module: `mdio_slave`

## Requirements
- R1: After reset, and after any framing error, no frame is acted on until at least 32 consecutive ones have been sampled on MDIO. A run of 31 ones followed by a zero is not enough.
- R2: Once synchronised, frames may follow one another with no preamble between them.
- R3: MDIO is sampled on the rising edge of MDC. A frame is: start bits 0 then 1; two opcode bits, 10 meaning read and 01 meaning write; a 5-bit device address sent MSB first; a 5-bit register address sent MSB first; two turnaround bits; and 16 data bits sent MSB first.
- R4: On a write, the turnaround must be 1 then 0. After the 16th data bit, `reg_wr` pulses for one system clock, with `reg_addr` and `reg_wdata` holding the decoded address and data.
- R5: On a read, `reg_rd` pulses for one system clock after the last register-address bit, with `reg_addr` valid. `reg_rdata` is captured at the clock edge that ends the cycle in which `reg_rd` is high. `reg_wr` and `reg_rd` are never high together.
- R6: On a read, `mdio_oe` stays low through the first turnaround bit. The slave drives 0 during the second turnaround bit, then sends the 16 data bits MSB first. It releases `mdio_oe` after the rising edge that samples the last data bit.
- R7: If the device address differs from `phy_addr_cfg`, the slave never drives MDIO and raises no strobe. It still tracks the frame, so the next frame needs no preamble.
- R8: An opcode of 00 or 11 is invalid. The frame is abandoned and R1 applies again.
- R9: A write whose turnaround is not 1 then 0 produces no write, and R1 applies again.
- R10: A start code other than 0 then 1 makes the block abandon the frame, and R1 applies again.
- R11: While reset is held, `mdio_oe`, `reg_wr` and `reg_rd` are low on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the MDC rate |
| rst_n | input | 1 | Synchronous active-low reset |
| mdc | input | 1 | Management clock from the master |
| mdio_in | input | 1 | Value sensed on the MDIO pad |
| phy_addr_cfg | input | 5 | Device address this slave answers to |
| mdio_out | output | 1 | Value to drive on MDIO while enabled |
| mdio_oe | output | 1 | Output enable for the MDIO pad |
| reg_addr | output | 5 | Register address of the current access |
| reg_wdata | output | 16 | Write data, valid with `reg_wr` |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 16 | Read data, valid while `reg_rd` is high |

## Verification
The assertions assume that each MDC high phase and each low phase lasts at least two system clocks. They also assume that MDIO is stable across each rising edge of MDC, and that `reg_rdata` is valid in the cycle `reg_rd` is high. The bench keeps within these limits. It holds MDC high and low for four system clocks each and changes its own MDIO value only while MDC is low. Its register model returns read data combinationally from the presented address. On the pad, the bench models the pull-up by letting the line read one whenever neither side drives it.

// File: rtl/mdio_slv_pkg.sv
// Package: shared sizes and the frame-parser state type for the management slave.
// Assumes: clause 22 field widths; the parser walks the states in the listed order.
package mdio_slv_pkg;
    localparam int PHY_AW = 5;
    localparam int REG_DW = 16;

    typedef enum logic [2:0] {
        ST_HUNT,   // waiting for the synchronising run of ones
        ST_IDLE,   // synchronised, waiting for the first start bit
        ST_START,  // expecting the second start bit
        ST_OP,     // two opcode bits
        ST_PHY,    // device address bits
        ST_REG,    // register address bits
        ST_TA,     // two turnaround bits
        ST_DATA    // sixteen data bits
    } frame_st_t;
endpackage

// File: rtl/mdio_slv_sampler.sv
// Module: brings MDC and MDIO into the system clock and reports one strobe per
// rising MDC edge, together with the MDIO value sampled at that edge.
// Assumes: each MDC phase lasts at least two system clocks; MDIO is stable across the rising edge.
module mdio_slv_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    input  logic mdio_in,
    output logic bit_stb,
    output logic bit_val
);
    logic [SYNC_STAGES-1:0] mdc_sync;
    logic [SYNC_STAGES-1:0] dat_sync;
    logic                   mdc_prev;

    // Shift both lines through matched synchroniser chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_sync <= '0;
            dat_sync <= '1;
            mdc_prev <= 1'b0;
        end else begin
            mdc_sync <= {mdc_sync[SYNC_STAGES-2:0], mdc};
            dat_sync <= {dat_sync[SYNC_STAGES-2:0], mdio_in};
            mdc_prev <= mdc_sync[SYNC_STAGES-1];
        end
    end

    // Register the rising-edge strobe and the sampled data bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_stb <= 1'b0;
            bit_val <= 1'b1;
        end else begin
            bit_stb <= mdc_sync[SYNC_STAGES-1] & ~mdc_prev;
            bit_val <= dat_sync[SYNC_STAGES-1];
        end
    end

    p_stb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb);
endmodule

// File: rtl/mdio_slv_preamble.sv
// Module: counts consecutive sampled ones and saturates at the preamble length.
// Assumes: `clear` takes priority over a sampled bit in the same cycle.
module mdio_slv_preamble #(
    parameter int LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic bit_val,
    input  logic clear,
    output logic seen
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(LEN);

    logic [CW-1:0] ones_cnt;

    // Count the run of ones; a zero or a clear restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ones_cnt <= '0;
        end else if (bit_stb) begin
            if (!bit_val)             ones_cnt <= '0;
            else if (ones_cnt != FULL) ones_cnt <= ones_cnt + 1'b1;
        end
    end

    assign seen = (ones_cnt == FULL);

    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ones_cnt <= FULL);
    p_zero_restarts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && !bit_val) |=> !seen);
endmodule

// File: rtl/mdio_slave.sv
// Module: management-bus slave. It parses frames bit by bit, hands register
// accesses to a parallel port, and returns read data through an output enable.
// Assumes: reg_rdata is valid while reg_rd is high; the system clock runs at four
// or more times MDC.
module mdio_slave
    import mdio_slv_pkg::*;
#(
    parameter int ADDR_W       = PHY_AW,
    parameter int DATA_W       = REG_DW,
    parameter int PREAMBLE_LEN = 32,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdc,
    input  logic              mdio_in,
    input  logic [ADDR_W-1:0] phy_addr_cfg,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    logic              bit_stb, bit_val, pre_seen, frame_err;
    frame_st_t         state;
    logic [CNT_W-1:0]  cnt;
    logic              op_hi, is_rd, phy_match, ta_hi;
    logic [ADDR_W-1:0] phy_sh, reg_sh;
    logic [DATA_W-1:0] data_sh;

    mdio_slv_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(mdio_in),
        .bit_stb(bit_stb), .bit_val(bit_val)
    );

    mdio_slv_preamble #(.LEN(PREAMBLE_LEN)) u_preamble (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
        .clear(frame_err), .seen(pre_seen)
    );

    // Flag a bad start bit, a bad opcode or a bad write turnaround.
    always_comb begin
        frame_err = 1'b0;
        if (bit_stb) begin
            case (state)
                ST_START: frame_err = !bit_val;
                ST_OP:    frame_err = (cnt != '0) && (op_hi == bit_val);
                ST_TA:    frame_err = !is_rd && (cnt != '0) && !(ta_hi && !bit_val);
                default:  frame_err = 1'b0;
            endcase
        end
    end

    // Frame parser: walk the fields, raise strobes and drive read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_HUNT;
            cnt       <= '0;
            op_hi     <= 1'b0;
            is_rd     <= 1'b0;
            phy_match <= 1'b0;
            ta_hi     <= 1'b0;
            phy_sh    <= '0;
            reg_sh    <= '0;
            data_sh   <= '0;
            mdio_out  <= 1'b0;
            mdio_oe   <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
        end else begin
            reg_wr <= 1'b0;
            reg_rd <= 1'b0;
            if (reg_rd) data_sh <= reg_rdata;
            if (bit_stb) begin
                if (frame_err) begin
                    state   <= ST_HUNT;
                    mdio_oe <= 1'b0;
                end else begin
                    case (state)
                        ST_HUNT:  if (pre_seen && !bit_val) state <= ST_START;
                        ST_IDLE:  if (!bit_val) state <= ST_START;
                        ST_START: begin
                            state <= ST_OP;
                            cnt   <= '0;
                        end
                        ST_OP: begin
                            if (cnt == '0) begin
                                op_hi <= bit_val;
                                cnt   <= cnt + 1'b1;
                            end else begin
                                is_rd <= op_hi;
                                state <= ST_PHY;
                                cnt   <= '0;
                            end
                        end
                        ST_PHY: begin
                            phy_sh <= {phy_sh[ADDR_W-2:0], bit_val};
                            if (cnt == ADDR_LAST) begin
                                phy_match <= ({phy_sh[ADDR_W-2:0], bit_val} == phy_addr_cfg);
                                state     <= ST_REG;
                                cnt       <= '0;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        ST_REG: begin
                            reg_sh <= {reg_sh[ADDR_W-2:0], bit_val};
                            if (cnt == ADDR_LAST) begin
                                reg_addr <= {reg_sh[ADDR_W-2:0], bit_val};
                                reg_rd   <= is_rd && phy_match;
                                state    <= ST_TA;
                                cnt      <= '0;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        ST_TA: begin
                            if (cnt == '0) begin
                                ta_hi <= bit_val;
                                cnt   <= cnt + 1'b1;
                                if (is_rd && phy_match) begin
                                    mdio_oe  <= 1'b1;
                                    mdio_out <= 1'b0;
                                end
                            end else begin
                                state <= ST_DATA;
                                cnt   <= '0;
                                if (is_rd && phy_match) begin
                                    mdio_out <= data_sh[DATA_W-1];
                                    data_sh  <= {data_sh[DATA_W-2:0], 1'b0};
                                end
                            end
                        end
                        ST_DATA: begin
                            if (is_rd) begin
                                if (phy_match) begin
                                    if (cnt == DATA_LAST) begin
                                        mdio_oe <= 1'b0;
                                    end else begin
                                        mdio_out <= data_sh[DATA_W-1];
                                        data_sh  <= {data_sh[DATA_W-2:0], 1'b0};
                                    end
                                end
                            end else begin
                                data_sh <= {data_sh[DATA_W-2:0], bit_val};
                            end
                            if (cnt == DATA_LAST) begin
                                state <= ST_IDLE;
                                if (!is_rd && phy_match) begin
                                    reg_wr    <= 1'b1;
                                    reg_wdata <= {data_sh[DATA_W-2:0], bit_val};
                                end
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        default: state <= ST_HUNT;
                    endcase
                end
            end
        end
    end

    p_reset_quiet_r11: assert property (@(posedge clk)
        !rst_n |=> (!mdio_oe && !reg_wr && !reg_rd));
    p_first_drive_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_out);
    p_drive_needs_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> phy_match);
    p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);
    p_rd_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));
    p_hunt_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT) |-> !mdio_oe);
endmodule

// File: tb/mdio_slave_tb.sv
// Bench: directed scenarios. Each task drives frames as a management master and checks its own results.
module mdio_slave_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdc = 1'b0;
    logic        mdo = 1'b1;
    logic [4:0]  phy_cfg = 5'h0B;
    logic        mdio_out, mdio_oe, reg_wr, reg_rd;
    logic [4:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        line;
    logic [15:0] mem [32];
    int          tests = 0, fails = 0;
    int          wr_cnt = 0, rd_cnt = 0;
    logic [4:0]  last_wa;
    logic [15:0] last_wd;
    bit          oe_seen = 0;

    always #5 clk = ~clk;

    assign line      = mdio_oe ? mdio_out : mdo;
    assign reg_rdata = mem[reg_addr];

    mdio_slave u_dut (
        .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(line),
        .phy_addr_cfg(phy_cfg), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    // Register model and strobe monitor.
    always @(posedge clk) begin
        if (rst_n) begin
            if (reg_wr) begin
                wr_cnt++;
                last_wa = reg_addr;
                last_wd = reg_wdata;
                mem[reg_addr] = reg_wdata;
            end
            if (reg_rd) rd_cnt++;
            if (mdio_oe) oe_seen = 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, output logic s);
        @(negedge clk) mdo = b;
        repeat (3) @(negedge clk);
        mdc = 1'b1;
        s = line;
        repeat (4) @(negedge clk);
        mdc = 1'b0;
    endtask

    task automatic ones(input int n);
        logic s;
        for (int i = 0; i < n; i++) send_bit(1'b1, s);
    endtask

    task automatic frame(input logic [1:0] st, input logic [1:0] op, input logic [4:0] phy,
                         input logic [4:0] ra, input logic [1:0] ta, input logic [15:0] wd,
                         input bit rdmode, output logic [15:0] got, output logic [1:0] ta_seen);
        logic [31:0] v;
        logic s;
        v = {st, op, phy, ra, (rdmode ? 2'b11 : ta), (rdmode ? 16'hFFFF : wd)};
        got = '0;
        ta_seen = '0;
        for (int i = 31; i >= 0; i--) begin
            send_bit(v[i], s);
            if (i == 17) ta_seen[1] = s;
            if (i == 16) ta_seen[0] = s;
            if (i <= 15) got[i] = s;
        end
        mdo = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic do_write(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd);
        logic [15:0] g;
        logic [1:0] t;
        frame(2'b01, 2'b01, phy, ra, 2'b10, wd, 1'b0, g, t);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!mdio_oe && !reg_wr && !reg_rd, "R11 reset outputs", {mdio_oe, reg_wr, reg_rd}, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_short_preamble;
        int w0 = wr_cnt;
        ones(31);
        do_write(phy_cfg, 5'd3, 16'h1234);
        chk(wr_cnt == w0, "R1 31 ones not enough", wr_cnt, w0);
        do_write(phy_cfg, 5'd3, 16'h1234);
        chk(wr_cnt == w0, "R1 no preamble ignored", wr_cnt, w0);
    endtask

    task automatic t_sync_write;
        int w0 = wr_cnt;
        ones(32);
        do_write(phy_cfg, 5'd5, 16'hA5C3);
        chk(wr_cnt == w0 + 1, "R4 write strobe count", wr_cnt, w0 + 1);
        chk(last_wa == 5'd5, "R3 write address", last_wa, 5);
        chk(last_wd == 16'hA5C3, "R4 write data", last_wd, 16'hA5C3);
        do_write(phy_cfg, 5'd31, 16'h8001);
        chk(wr_cnt == w0 + 2 && last_wa == 5'd31, "R2 back-to-back write", last_wa, 31);
        chk(last_wd == 16'h8001, "R2 back-to-back data", last_wd, 16'h8001);
    endtask

    task automatic t_read;
        logic [15:0] g;
        logic [1:0] t;
        int r0 = rd_cnt;
        frame(2'b01, 2'b10, phy_cfg, 5'd5, 2'b11, 16'h0, 1'b1, g, t);
        chk(rd_cnt == r0 + 1, "R5 read strobe count", rd_cnt, r0 + 1);
        chk(t == 2'b10, "R6 turnaround 1 then driven 0", t, 2'b10);
        chk(g == 16'hA5C3, "R6 read data reg5", g, 16'hA5C3);
        chk(!mdio_oe, "R6 release after last bit", mdio_oe, 0);
        frame(2'b01, 2'b10, phy_cfg, 5'd31, 2'b11, 16'h0, 1'b1, g, t);
        chk(g == 16'h8001, "R5 read data reg31", g, 16'h8001);
    endtask

    task automatic t_mismatch;
        logic [15:0] g;
        logic [1:0] t;
        int r0 = rd_cnt, w0 = wr_cnt;
        oe_seen = 0;
        frame(2'b01, 2'b10, phy_cfg ^ 5'h01, 5'd5, 2'b11, 16'h0, 1'b1, g, t);
        chk(!oe_seen && rd_cnt == r0, "R7 foreign read not driven", {oe_seen, rd_cnt[7:0]}, r0);
        do_write(phy_cfg ^ 5'h10, 5'd5, 16'hDEAD);
        chk(wr_cnt == w0, "R7 foreign write ignored", wr_cnt, w0);
        do_write(phy_cfg, 5'd7, 16'h0F0F);
        chk(wr_cnt == w0 + 1 && last_wd == 16'h0F0F, "R7 tracked, next frame accepted", last_wd, 16'h0F0F);
    endtask

    task automatic t_bad_op(input logic [1:0] op);
        logic [15:0] g;
        logic [1:0] t;
        int w0 = wr_cnt;
        frame(2'b01, op, phy_cfg, 5'd9, 2'b10, 16'h5550, 1'b0, g, t);
        do_write(phy_cfg, 5'd9, 16'h1110);
        chk(wr_cnt == w0, "R8 invalid opcode forces resync", wr_cnt, w0);
        ones(32);
        do_write(phy_cfg, 5'd9, 16'h2220);
        chk(wr_cnt == w0 + 1 && last_wd == 16'h2220, "R8 resync recovers", last_wd, 16'h2220);
    endtask

    task automatic t_bad_ta;
        logic [15:0] g;
        logic [1:0] t;
        int w0 = wr_cnt;
        frame(2'b01, 2'b01, phy_cfg, 5'd4, 2'b00, 16'h7770, 1'b0, g, t);
        chk(wr_cnt == w0, "R9 bad turnaround no write", wr_cnt, w0);
        do_write(phy_cfg, 5'd4, 16'h6660);
        chk(wr_cnt == w0, "R9 bad turnaround forces resync", wr_cnt, w0);
        ones(32);
    endtask

    task automatic t_bad_start;
        logic [15:0] g;
        logic [1:0] t;
        int w0 = wr_cnt;
        frame(2'b00, 2'b01, phy_cfg, 5'd2, 2'b10, 16'h4440, 1'b0, g, t);
        do_write(phy_cfg, 5'd2, 16'h3330);
        chk(wr_cnt == w0, "R10 bad start forces resync", wr_cnt, w0);
        ones(32);
        do_write(phy_cfg, 5'd2, 16'h3330);
        chk(wr_cnt == w0 + 1 && last_wa == 5'd2, "R10 resync recovers", last_wa, 2);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mem[i] = '0;
        repeat (4) @(posedge clk);
        t_reset();
        repeat (4) @(negedge clk);
        t_short_preamble();
        t_sync_write();
        t_read();
        t_mismatch();
        t_bad_op(2'b11);
        t_bad_op(2'b00);
        t_bad_ta();
        t_bad_start();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule